// File: doc/BRIEF.md
# Instruction Cycle and Fetch Sequencer

This block paces a small accumulator-style core with 16-bit program words. It divides the oscillator clock into instruction cycles of four phases and drives one-hot phase strobes. It also pulses `cycle_done` on the last phase of each cycle. Fetch runs one cycle ahead of execution. While the word held in the instruction register executes, the word after it is read from program memory at the word address `pm_addr`. At the end of each cycle that fetched word moves into the instruction register and the program counter steps by one.

An external decoder looks at `ir_word` and `ir_second` and returns flags: two-word start, control transfer taken (with a target), and skip taken. The sequencer samples these flags on the last phase of the cycle. From them it decides what the next cycle is:
- a normal execute,
- the second word of a two-word instruction, or
- a flush cycle that discards an already-fetched word.

A word whose four top bits are all ones is treated as a NOP when it reaches the first-word slot on its own. The `exec_en` and `nop_insert` outputs tell the rest of the core whether the current cycle commits work.

Top module: `instr_fetch_seq`

## Requirements
- R1: The `phase` output is one-hot. It rotates from bit 0 up to bit PHASES-1, one position per clock, so an instruction cycle is exactly PHASES clocks (4 by default). `cycle_done` is high only while the last phase bit is set.
- R2: While `rst` is high at a clock edge, the block returns to phase bit 0, program counter 0 and a flush cycle. The first cycle after reset shows `pm_addr` = 0, `nop_insert` = 1 and `exec_en` = 0.
- R3: A one-word instruction with no flag set occupies one cycle with `exec_en` = 1. The word at the next address executes in the following cycle.
- R4: A taken skip (`dec_skip` = 1 on a one-word instruction) costs two cycles. The second is a NOP cycle whose `ir_word` is the next sequential word, which is discarded. Execution resumes two addresses past the skip.
- R5: A taken control transfer on a one-word instruction (`dec_jump` = 1) costs two cycles. The second is a NOP cycle, and the word at `dec_target` executes next.
- R6: When `dec_two_word` = 1 on a first word, the next cycle carries the following word with `ir_second` = 1 and `exec_en` = 1. When two-word is set, jump and skip flags on the first word have no effect. A two-word instruction that is not taken costs two cycles.
- R7: `dec_jump` = 1 during the second-word cycle loads `dec_target`, followed by one NOP cycle, for three cycles in total.
- R8: A word whose bits [15:12] are 4'hF reaching the first-word slot is an orphan second word. It gives `exec_en` = 0 and `nop_insert` = 1 for one cycle, its decoder flags are ignored, and the next word follows sequentially.
- R9: When `dec_jump` and `dec_skip` are both set, the jump wins. Decoder flags presented during a flush cycle have no effect.
- R10: `pm_addr` is a word address. It is constant within an instruction cycle and changes only at the cycle boundary, to the old value plus one (wrapping), or to the target on a taken transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_addr | output | ADDR_W | Program memory word address being fetched |
| pm_data | input | WORD_W | Program word at `pm_addr`, valid by the last phase |
| dec_two_word | input | 1 | Current first word starts a two-word instruction |
| dec_jump | input | 1 | Control transfer taken on the current word |
| dec_skip | input | 1 | Conditional skip taken on the current word |
| dec_target | input | ADDR_W | Word address loaded on a taken transfer |
| phase | output | PHASES | One-hot phase strobes |
| cycle_done | output | 1 | High on the last phase of each instruction cycle |
| ir_word | output | WORD_W | Word held in the instruction register this cycle |
| ir_second | output | 1 | `ir_word` is the second word of a two-word instruction |
| exec_en | output | 1 | Current cycle commits the instruction |
| nop_insert | output | 1 | Current cycle executes as a NOP |

## Verification
The bench builds the block with ADDR_W = 8, WORD_W = 16, PHASES = 4 and MARK_W = 4. A 256-word space lets a behavioural program memory cover every address. With that space, random transfer targets can land anywhere, and sequential runs wrap from the top address back to 0. A directed program chains every cycle-count case. It covers a skip landing on a second word and an orphan word carrying a jump flag. A seeded random program of mixed instruction classes is then run through a cycle-level reference model.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  // Kind of instruction cycle currently in progress
  typedef enum logic [1:0] {
    ST_FLUSH  = 2'd0,  // discarded word, executes as NOP
    ST_EXEC   = 2'd1,  // first or only word of an instruction
    ST_SECOND = 2'd2   // second word of a two-word instruction
  } seq_st_e;

endpackage

// File: rtl/ifs_phase_ring.sv
module ifs_phase_ring #(
  parameter int PHASES = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PHASES-1:0] phase,
  output logic              adv
);

  localparam logic [PHASES-1:0] FIRST = PHASES'(1);

  always_ff @(posedge clk) begin
    if (rst) phase <= FIRST;
    else     phase <= {phase[PHASES-2:0], phase[PHASES-1]};
  end

  // boundary strobe: last phase of the instruction cycle
  assign adv = phase[PHASES-1];

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    adv |=> phase == FIRST); // R1
  AST_PHASE_FIRST_MOVES: assert property (@(posedge clk) disable iff (rst)
    phase[0] |=> !phase[0]); // R1

endmodule

// File: rtl/ifs_pc.sv
module ifs_pc #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              load,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst)      pc <= '0;
    else if (adv) pc <= load ? target : pc + ONE;
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pc)); // R10
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    adv && !load |=> pc == $past(pc) + ONE); // R10
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
    adv && load |=> pc == $past(target)); // R5

endmodule

// File: rtl/ifs_seq.sv
module ifs_seq
  import ifs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int MARK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              two_word,
  input  logic              jump,
  input  logic              skip,
  output logic              load,
  output logic [WORD_W-1:0] ir,
  output logic              exec_en,
  output logic              nop_insert,
  output logic              ir_second
);

  localparam logic [MARK_W-1:0] MARK = '1;

  seq_st_e st, nxt;
  logic    orphan, take, fetch_marked;

  assign orphan       = (st == ST_EXEC) && (ir[WORD_W-1 -: MARK_W] == MARK);
  assign fetch_marked = fetch_word[WORD_W-1 -: MARK_W] == MARK;

  always_comb begin
    nxt  = st;
    take = 1'b0;
    unique case (st)
      ST_FLUSH: nxt = ST_EXEC;
      ST_EXEC: begin
        if (!orphan) begin
          if (two_word) nxt = ST_SECOND;
          else if (jump) begin
            nxt  = ST_FLUSH;
            take = 1'b1;
          end
          else if (skip) nxt = ST_FLUSH;
        end
      end
      ST_SECOND: begin
        if (jump) begin
          nxt  = ST_FLUSH;
          take = 1'b1;
        end
        else if (skip) nxt = ST_FLUSH;
        else           nxt = ST_EXEC;
      end
      default: nxt = ST_FLUSH;
    endcase
  end

  assign load = adv && take;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_FLUSH;
      ir         <= '0;
      exec_en    <= 1'b0;
      nop_insert <= 1'b1;
      ir_second  <= 1'b0;
    end
    else if (adv) begin
      st         <= nxt;
      ir         <= fetch_word;
      exec_en    <= (nxt == ST_SECOND) || (nxt == ST_EXEC && !fetch_marked);
      nop_insert <= (nxt == ST_FLUSH)  || (nxt == ST_EXEC && fetch_marked);
      ir_second  <= (nxt == ST_SECOND);
    end
  end

  AST_SKIP_FLUSH: assert property (@(posedge clk) disable iff (rst)
    adv && st == ST_EXEC && !orphan && !two_word && !jump && skip
    |=> nop_insert && !exec_en); // R4
  AST_JUMP_FLUSH: assert property (@(posedge clk) disable iff (rst)
    adv && load |=> nop_insert && st == ST_FLUSH); // R5
  AST_TWO_SECOND: assert property (@(posedge clk) disable iff (rst)
    adv && st == ST_EXEC && !orphan && two_word |=> ir_second && exec_en); // R6
  AST_ORPHAN_NOP: assert property (@(posedge clk) disable iff (rst)
    adv && orphan |=> st == ST_EXEC && !ir_second); // R8
  AST_FLUSH_IGNORES: assert property (@(posedge clk) disable iff (rst)
    adv && st == ST_FLUSH |=> st == ST_EXEC); // R9
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ir) && $stable(exec_en)); // R1

endmodule

// File: rtl/instr_fetch_seq.sv
module instr_fetch_seq #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int PHASES = 4,
  parameter int MARK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] pm_addr,
  input  logic [WORD_W-1:0] pm_data,
  input  logic              dec_two_word,
  input  logic              dec_jump,
  input  logic              dec_skip,
  input  logic [ADDR_W-1:0] dec_target,
  output logic [PHASES-1:0] phase,
  output logic              cycle_done,
  output logic [WORD_W-1:0] ir_word,
  output logic              ir_second,
  output logic              exec_en,
  output logic              nop_insert
);

  logic adv, load;

  ifs_phase_ring #(.PHASES(PHASES)) ring_i (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .adv   (adv)
  );

  ifs_pc #(.ADDR_W(ADDR_W)) pc_i (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .load   (load),
    .target (dec_target),
    .pc     (pm_addr)
  );

  ifs_seq #(.WORD_W(WORD_W), .MARK_W(MARK_W)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .fetch_word (pm_data),
    .two_word   (dec_two_word),
    .jump       (dec_jump),
    .skip       (dec_skip),
    .load       (load),
    .ir         (ir_word),
    .exec_en    (exec_en),
    .nop_insert (nop_insert),
    .ir_second  (ir_second)
  );

  assign cycle_done = adv;

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
    exec_en != nop_insert); // R3
  AST_SECOND_EXECS: assert property (@(posedge clk) disable iff (rst)
    ir_second |-> exec_en); // R6

endmodule

// File: tb/instr_fetch_seq_tb.sv
module instr_fetch_seq_tb_top;

  localparam int AW = 8;
  localparam int WW = 16;
  localparam int PH = 4;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic          two;
    logic          jmp;
    logic          skp;
    logic [AW-1:0] tgt;
  } dec_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] pm_addr;
  logic [WW-1:0] pm_data;
  logic [PH-1:0] phase;
  logic          cycle_done, ir_second, exec_en, nop_insert;
  logic [WW-1:0] ir_word;
  dec_t          dec;

  logic [WW-1:0] mem [DEPTH];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  assign pm_data = mem[pm_addr];

  // Behavioural decoder: class in bits [15:12], target in low bits
  // 0,5: plain  1: skip  2: jump  3: two-word start  4: skip+jump
  // F: second-word marker, bit 11 = branch taken
  function automatic dec_t decode(input logic [WW-1:0] w, input logic sec);
    dec_t d;
    d = '0;
    d.tgt = w[AW-1:0];
    if (sec) d.jmp = w[11];
    else begin
      case (w[15:12])
        4'h1: d.skp = 1'b1;
        4'h2: d.jmp = 1'b1;
        4'h3: d.two = 1'b1;
        4'h4: begin d.skp = 1'b1; d.jmp = 1'b1; end
        4'hF: d.jmp = w[11];
        default: ;
      endcase
    end
    return d;
  endfunction

  always_comb dec = decode(ir_word, ir_second);

  instr_fetch_seq #(.ADDR_W(AW), .WORD_W(WW), .PHASES(PH), .MARK_W(4)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .pm_addr      (pm_addr),
    .pm_data      (pm_data),
    .dec_two_word (dec.two),
    .dec_jump     (dec.jmp),
    .dec_skip     (dec.skp),
    .dec_target   (dec.tgt),
    .phase        (phase),
    .cycle_done   (cycle_done),
    .ir_word      (ir_word),
    .ir_second    (ir_second),
    .exec_en      (exec_en),
    .nop_insert   (nop_insert)
  );

  // reference model: 0 flush, 1 execute, 2 second word
  int            mst;
  logic [AW-1:0] mpc;
  logic [WW-1:0] mir;
  int            cyc;
  logic [WW-1:0] rec_word [32];
  logic          rec_exec [32];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_exec_f();
    return (mst == 1 && mir[15:12] != 4'hF) || mst == 2;
  endfunction

  task automatic model_advance();
    dec_t          d;
    logic [WW-1:0] fetched;
    bit            take;
    fetched = mem[mpc];
    d = decode(mir, mst == 2);
    take = 0;
    case (mst)
      0: mst = 1;
      1: if (mir[15:12] != 4'hF) begin
           if (d.two) mst = 2;
           else if (d.jmp) begin mst = 0; take = 1; end
           else if (d.skp) mst = 0;
         end
      default: begin
           if (d.jmp) begin mst = 0; take = 1; end
           else if (d.skp) mst = 0;
           else mst = 1;
         end
    endcase
    mir = fetched;
    mpc = take ? d.tgt : mpc + 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mst = 0; mpc = '0; mir = '0; cyc = 0;
    // R2: state directly after reset
    chk(pm_addr == 0, "R2", "pm_addr", pm_addr, 0);
    chk(nop_insert == 1'b1 && exec_en == 1'b0, "R2", "nop/exec",
        {nop_insert, exec_en}, 2'b10);
    chk(phase == PH'(1) && !cycle_done, "R2", "phase", phase, 1);
  endtask

  // called at the negedge of the first phase of a cycle
  task automatic step_cycle();
    bit ee;
    ee = exp_exec_f();
    chk(exec_en == ee, "R3", "exec_en", exec_en, ee);
    chk(nop_insert == !ee, "R8", "nop_insert", nop_insert, !ee);
    chk(ir_second == (mst == 2), "R6", "ir_second", ir_second, mst == 2);
    chk(ir_word == mir, "R3", "ir_word", ir_word, mir);
    chk(pm_addr == mpc, "R10", "pm_addr", pm_addr, mpc);
    chk(phase == PH'(1) && !cycle_done, "R1", "phase0", phase, 1);
    if (cyc < 32) begin
      rec_word[cyc] = ir_word;
      rec_exec[cyc] = exec_en;
    end
    for (int k = 1; k < PH; k++) begin
      @(negedge clk);
      chk(phase == PH'(1 << k), "R1", "phase", phase, 1 << k);
      chk(cycle_done == (k == PH - 1), "R1", "cycle_done", cycle_done, k == PH - 1);
      chk(pm_addr == mpc, "R10", "pm_addr stable", pm_addr, mpc);
    end
    model_advance();
    cyc++;
    @(negedge clk);
  endtask

  // hand-derived timeline of the directed program: {exec, address}
  function automatic logic [8:0] dir_exp(input int c);
    case (c)
      1:  return {1'b1, 8'd0};
      2:  return {1'b1, 8'd1};
      3:  return {1'b0, 8'd2};
      4:  return {1'b1, 8'd3};
      5:  return {1'b1, 8'd4};
      6:  return {1'b1, 8'd5};
      7:  return {1'b0, 8'd6};
      8:  return {1'b1, 8'd10};
      9:  return {1'b1, 8'd11};
      10: return {1'b0, 8'd12};
      11: return {1'b0, 8'd20};
      12: return {1'b1, 8'd21};
      13: return {1'b1, 8'd22};
      14: return {1'b0, 8'd23};
      15: return {1'b0, 8'd24};
      16: return {1'b1, 8'd25};
      17: return {1'b0, 8'd26};
      default: return {1'b1, 8'd40};
    endcase
  endfunction

  function automatic string dir_tag(input int c);
    if (c <= 1)  return "R3";
    if (c <= 3)  return "R4";
    if (c <= 5)  return "R6";
    if (c <= 7)  return "R5";
    if (c <= 10) return "R7";
    if (c <= 12) return "R8";
    if (c <= 15) return "R4";
    return "R9";
  endfunction

  initial begin
    logic [8:0] e;
    // directed program
    for (int i = 0; i < DEPTH; i++) mem[i] = WW'(i);
    mem[0]  = 16'h0001;  // plain
    mem[1]  = 16'h1002;  // skip taken
    mem[2]  = 16'h2032;  // skipped; its jump flag must be ignored (R9)
    mem[3]  = 16'h3003;  // two-word start
    mem[4]  = 16'hF012;  // second word, not taken
    mem[5]  = 16'h200A;  // jump to 10
    mem[10] = 16'h300B;  // two-word branch
    mem[11] = 16'hF814;  // second word, taken to 20 (R7)
    mem[20] = 16'hF83C;  // orphan with jump flag (R8)
    mem[21] = 16'h0015;
    mem[22] = 16'h1016;  // skip over a two-word instruction
    mem[23] = 16'h3017;
    mem[24] = 16'hF018;  // reached alone: NOP
    mem[25] = 16'h4028;  // skip and jump to 40: jump wins (R9)
    mem[40] = 16'h0029;

    do_reset();
    for (int c = 0; c < 19; c++) step_cycle();
    for (int c = 1; c < 19; c++) begin
      e = dir_exp(c);
      chk(rec_exec[c] == e[8], dir_tag(c), "directed exec", rec_exec[c], e[8]);
      chk(rec_word[c] == mem[e[7:0]], dir_tag(c), "directed word",
          rec_word[c], mem[e[7:0]]);
    end

    // random program
    void'($urandom(32'd2718));
    for (int i = 0; i < DEPTH; i++) begin
      int r;
      r = $urandom_range(15, 0);
      if (r <= 6)       mem[i] = {4'h0, 12'($urandom)};
      else if (r <= 8)  mem[i] = {4'h1, 12'($urandom)};
      else if (r <= 10) mem[i] = {4'h2, 12'($urandom)};
      else if (r <= 12) begin
        mem[i] = {4'h3, 12'($urandom)};
        if (i < DEPTH - 1) begin
          mem[i + 1] = {4'hF, 1'($urandom), 11'($urandom)};
          i++;
        end
      end
      else if (r == 13) mem[i] = {4'h4, 12'($urandom)};
      else if (r == 14) mem[i] = {4'hF, 12'($urandom)};
      else              mem[i] = {4'h5, 12'($urandom)};
    end
    do_reset();
    for (int c = 0; c < 1500; c++) step_cycle();

    // sequential wrap of the address space (R10)
    for (int i = 0; i < DEPTH; i++) mem[i] = {4'h0, 12'(i)};
    do_reset();
    for (int c = 0; c < DEPTH + 8; c++) step_cycle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule